// File: doc/BRIEF.md
# Channel Event Flag Bank

This block holds one sticky event flag for each channel of a timer. A one-cycle pulse on a channel's event input sets that channel's flag. Software sees the flags in two places: all of them at once in a summary register, and each one alone in bit 0 of its own channel register. Both places show the same storage bit, so they always agree.

Software clears a flag with a two-step handshake. A read-strobe cycle that returns the flag as 1 arms it. A later write of 0 to that bit, through either register, clears it. Any event on that channel after the arming read cancels the arm, so an event that arrives during the handshake is never lost. The first write that reaches a flag's bit also cancels the arm, whatever value it carries. An interrupt output goes high while any flag is set whose channel interrupt enable input is high.

Address decode uses word addresses. The summary register is at address 0. Channel n has its register at address n+1. Read data follows the address combinationally. Only cycles with the read strobe high arm flags. The asynchronous reset is released through a two-stage synchronizer.

Top module: `chan_flag_bank`

## Requirements
- R1: After reset every flag reads 0 and `irq_o` is 0.
- R2: The summary register is at address 0. Bit n (n < NCH) holds channel n's flag, and bits 31 to NCH always read 0 whatever was written there.
- R3: An event pulse on `evt_i[n]` makes flag n read 1 from the cycle after the pulse.
- R4: The channel n register is at address n+1. Bit 0 is flag n and bits 31 to 1 read 0. Its bit 0 always equals bit n of the summary register.
- R5: A write of 0 leaves a flag set unless a read-strobe cycle returned that flag as 1 since the flag's last write or event. Bus data presented without the read strobe does not arm.
- R6: Writing 1 to a flag's bit never changes the flag, and it uses up the arm: a write of 0 that follows it leaves the flag set.
- R7: An event on a channel after its arming read and before the clearing write makes that write leave the flag set.
- R8: An event in the same cycle as an armed write of 0 leaves the flag set.
- R9: Reading the summary register and then writing 0x00 to it clears every flag that the read returned as 1 and that saw no event in between. Other flags keep their state.
- R10: `irq_o` is high exactly when some channel has both its flag and `irq_en_i` bit set.
- R11: A read through one register arms a flag for a clear through the other register. A write to channel n's register does not touch any other channel's flag or arm.
- R12: Addresses above NCH read 0, and writes to them change no flag and no arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Word address |
| bus_rd | input | 1 | Read strobe; arms flags that read as 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| evt_i | input | NCH | Channel event pulses |
| irq_en_i | input | NCH | Per-channel interrupt enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an event that lands inside the clear handshake. It can arrive in a cycle between the arming read and the zeroing write, or in the same cycle as that write. The stimulus is built from single-cycle bus tasks, so an event pulse can be placed in either slot. A sweep over all 256 event patterns alternates between the two placements, using a second, derived pattern as the racing events. A per-cycle reference model tracks flags and arms. Reads that carry no strobe let the bench observe state without arming anything.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int unsigned CFB_DW       = 32;
  localparam int unsigned CFB_SUM_ADDR = 0;
  localparam int unsigned CFB_CH_BASE  = 1;

  // per-channel bus access after decode
  typedef struct packed {
    logic rd;    // read strobe hits this flag
    logic wr;    // write strobe hits this flag
    logic wbit;  // data bit aimed at this flag
  } cfb_acc_t;
endpackage

// File: rtl/cfb_rstsync.sv
module cfb_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfb_regif.sv
module cfb_regif
  import cfb_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 4
) (
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [CFB_DW-1:0]      bus_wdata,
  input  logic [NCH-1:0]         flags,
  output cfb_acc_t [NCH-1:0]     acc,
  output logic [CFB_DW-1:0]      bus_rdata
);
  localparam logic [AW-1:0] SUM_A = AW'(CFB_SUM_ADDR);

  logic           sum_sel;
  logic [NCH-1:0] ch_sel;
  logic           unused_wdata;

  assign sum_sel      = (bus_addr == SUM_A);
  assign unused_wdata = ^bus_wdata[CFB_DW-1:NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [AW-1:0] CH_A = AW'(CFB_CH_BASE + i);
    assign ch_sel[i]   = (bus_addr == CH_A);
    assign acc[i].rd   = bus_rd & (sum_sel | ch_sel[i]);
    assign acc[i].wr   = bus_wr & (sum_sel | ch_sel[i]);
    assign acc[i].wbit = sum_sel ? bus_wdata[i] : bus_wdata[0];
  end

  always_comb begin
    bus_rdata = '0;
    if (sum_sel) begin
      bus_rdata[NCH-1:0] = flags;
    end
    for (int j = 0; j < NCH; j++) begin
      if (ch_sel[j]) begin
        bus_rdata[0] = flags[j];
      end
    end
  end
endmodule

// File: rtl/cfb_chan.sv
module cfb_chan
  import cfb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     evt,
  input  cfb_acc_t acc,
  output logic     flag,
  output logic     armed
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic upd_en;

  // next state: event beats every bus action
  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (evt) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (acc.wr) begin
      if (!acc.wbit && arm_q) begin
        flag_d = 1'b0;
      end
      arm_d = 1'b0;
    end else if (acc.rd && flag_q) begin
      arm_d = 1'b1;
    end
  end

  assign upd_en = evt | acc.wr | acc.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (upd_en) begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag  = flag_q;
  assign armed = arm_q;
endmodule

// File: rtl/chan_flag_bank.sv
module chan_flag_bank
  import cfb_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [CFB_DW-1:0] bus_wdata,
  output logic [CFB_DW-1:0] bus_rdata,
  input  logic [NCH-1:0]    evt_i,
  input  logic [NCH-1:0]    irq_en_i,
  output logic              irq_o
);
  logic               rst_q;
  logic [NCH-1:0]     flag_v;
  logic [NCH-1:0]     arm_v;
  cfb_acc_t [NCH-1:0] acc_v;

  cfb_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q)
  );

  cfb_regif #(.NCH(NCH), .AW(AW)) u_regif (
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .flags     (flag_v),
    .acc       (acc_v),
    .bus_rdata (bus_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    cfb_chan u_ch (
      .clk   (clk),
      .rst_n (rst_q),
      .evt   (evt_i[i]),
      .acc   (acc_v[i]),
      .flag  (flag_v[i]),
      .armed (arm_v[i])
    );
  end

  assign irq_o = |(flag_v & irq_en_i);
endmodule

// File: rtl/cfb_chk.sv
module cfb_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] evt,
  input logic [NCH-1:0] irq_en,
  input logic           irq,
  input logic [NCH-1:0] flags,
  input logic [NCH-1:0] armed,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_wr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata
);
  // R2
  sum_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == '0) |-> (bus_rdata[31:NCH] == '0));

  // R10
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(flags & irq_en));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    localparam logic [AW-1:0] CA = AW'(1 + i);
    logic one_wr;
    assign one_wr = bus_wr && (((bus_addr == '0) && bus_wdata[i]) ||
                               ((bus_addr == CA) && bus_wdata[0]));

    // R3
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);

    // R7
    evt_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> !armed[i]);

    // R5
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !armed[i]) |=> flags[i]);

    // R5
    clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> ($past(bus_wr) && $past(armed[i]) && !$past(evt[i])));

    // R6
    one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (one_wr && flags[i]) |=> flags[i]);

    // R4
    view_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == CA) |-> (bus_rdata == {31'b0, flags[i]}));
  end
endmodule

bind chan_flag_bank cfb_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .evt       (evt_i),
  .irq_en    (irq_en_i),
  .irq       (irq_o),
  .flags     (flag_v),
  .armed     (arm_v),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/sim_chan_flag_bank.sv
`timescale 1ns/1ps
module sim_chan_flag_bank;
  localparam int NCH = 8;
  localparam int AW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_rd = 1'b0;
  logic           bus_wr = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] evt = '0;
  logic [NCH-1:0] irq_en = '0;
  logic           irq;

  int checks = 0;
  int errors = 0;
  logic [NCH-1:0] mflag = '0;
  logic [NCH-1:0] marm = '0;

  always #4 clk = ~clk;

  chan_flag_bank #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_i(evt), .irq_en_i(irq_en), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
    int idx = int'(a) - 1;
    if (a == '0) return {{(32-NCH){1'b0}}, mflag};
    if (idx >= 0 && idx < NCH) return {31'b0, mflag[idx]};
    return 32'h0;
  endfunction

  // one bus cycle with optional events; model follows the requirements
  task automatic cyc(string tag, logic [AW-1:0] a, logic rd, logic wr,
                     logic [31:0] wd, logic [NCH-1:0] ev);
    logic [NCH-1:0] nf, na;
    logic hit, b;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; evt = ev;
    #1;
    if (rd) chk(tag, bus_rdata, exp_rd(a));
    for (int i = 0; i < NCH; i++) begin
      hit = (a == '0) || (int'(a) == i + 1);
      b   = (a == '0) ? wd[i] : wd[0];
      if (ev[i]) begin
        nf[i] = 1'b1; na[i] = 1'b0;
      end else if (wr && hit) begin
        nf[i] = (!b && marm[i]) ? 1'b0 : mflag[i]; na[i] = 1'b0;
      end else begin
        nf[i] = mflag[i];
        na[i] = (rd && hit && mflag[i]) ? 1'b1 : marm[i];
      end
    end
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_wr = 1'b0; evt = '0;
    mflag = nf; marm = na;
    chk({tag, " irq R10"}, {31'b0, irq}, {31'b0, |(mflag & irq_en)});
  endtask

  task automatic rd_reg(string tag, logic [AW-1:0] a);
    cyc(tag, a, 1'b1, 1'b0, 32'h0, '0);
  endtask

  task automatic wr_reg(string tag, logic [AW-1:0] a, logic [31:0] d);
    cyc(tag, a, 1'b0, 1'b1, d, '0);
  endtask

  task automatic pulse(string tag, logic [NCH-1:0] m);
    cyc(tag, '0, 1'b0, 1'b0, 32'h0, m);
  endtask

  // look at a register without the read strobe (no arming)
  task automatic peek(string tag, logic [AW-1:0] a, logic [31:0] lit);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, lit);
    chk({tag, " model"}, bus_rdata, exp_rd(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    peek("R1 flags after reset", 4'd0, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    pulse("R3 set", 8'h05);
    peek("R3 summary", 4'd0, 32'h05);
    peek("R4 ch0", 4'd1, 32'h1);
    peek("R4 ch1", 4'd2, 32'h0);
    peek("R4 ch2", 4'd3, 32'h1);

    wr_reg("R5 write without read", 4'd0, 32'h0);
    peek("R5 stays set", 4'd0, 32'h05);

    rd_reg("R6 arm", 4'd0);
    wr_reg("R6 write ones", 4'd0, 32'h05);
    peek("R6 ones keep", 4'd0, 32'h05);
    wr_reg("R6 zero after one", 4'd0, 32'h0);
    peek("R6 arm used up", 4'd0, 32'h05);

    rd_reg("R9 arm all", 4'd0);
    wr_reg("R9 clear all", 4'd0, 32'h0);
    peek("R9 cleared", 4'd0, 32'h0);

    pulse("R7 set", 8'h0C);
    rd_reg("R7 arm", 4'd0);
    pulse("R7 race event", 8'h04);
    wr_reg("R7 clear", 4'd0, 32'h0);
    peek("R7 racing flag kept", 4'd0, 32'h04);

    rd_reg("R8 arm", 4'd0);
    cyc("R8 same-cycle", 4'd0, 1'b0, 1'b1, 32'h0, 8'h04);
    peek("R8 flag kept", 4'd0, 32'h04);
    rd_reg("R9 arm", 4'd0);
    wr_reg("R9 clear", 4'd0, 32'h0);
    peek("R9 empty", 4'd0, 32'h0);

    pulse("R11 set", 8'h80);
    rd_reg("R11 arm via ch7 reg", 4'd8);
    wr_reg("R11 clear via summary", 4'd0, 32'h0);
    peek("R11 cleared", 4'd0, 32'h0);
    pulse("R11 set two", 8'h41);
    rd_reg("R11 arm via summary", 4'd0);
    wr_reg("R11 clear via ch6 reg", 4'd7, 32'h0);
    peek("R11 only ch6 cleared", 4'd0, 32'h01);
    wr_reg("R11 clear via ch0 reg", 4'd1, 32'h0);
    peek("R11 ch0 cleared", 4'd0, 32'h0);

    pulse("R12 set", 8'hFF);
    rd_reg("R12 arm", 4'd0);
    wr_reg("R12 unmapped write", 4'hF, 32'h0);
    peek("R12 unmapped read", 4'hF, 32'h0);
    peek("R12 flags kept", 4'd0, 32'hFF);
    wr_reg("R12 arm survived", 4'd0, 32'h0);
    peek("R12 cleared", 4'd0, 32'h0);

    pulse("R2 set", 8'h01);
    rd_reg("R2 arm", 4'd0);
    wr_reg("R2 upper ones", 4'd0, 32'hFFFF_FF00);
    peek("R2 upper zero", 4'd0, 32'h0);

    irq_en = 8'h10;
    pulse("R10 disabled channel", 8'h01);
    pulse("R10 enabled channel", 8'h10);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    rd_reg("R10 arm", 4'd0);
    wr_reg("R10 clear", 4'd0, 32'h0);
    chk("R10 irq low", {31'b0, irq}, 32'h0);

    for (int m = 0; m < 256; m++) begin
      logic [NCH-1:0] k;
      k = 8'((m * 29 + 7) & 255);
      irq_en = ~8'(m) ^ 8'h5A;
      pulse("R3 sweep set", 8'(m));
      rd_reg("R9 sweep arm", 4'd0);
      if (m % 2 == 0) begin
        pulse("R7 sweep race", k);
        wr_reg("R7 sweep clear", 4'd0, 32'h0);
      end else begin
        cyc("R8 sweep race", 4'd0, 1'b0, 1'b1, 32'h0, k);
      end
      peek("R9 sweep survivors", 4'd0, {24'h0, k});
      rd_reg("R9 sweep rearm", 4'd0);
      wr_reg("R9 sweep wipe", 4'd0, 32'h0);
      peek("R9 sweep empty", 4'd0, 32'h0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule